// File: doc/BRIEF.md
# Intermittent Resistance Burst Generator

This block produces a timed stream of resistance codes that steer fast digital potentiometers and switch banks, so that a physical wire can be made to behave like a flaky, intermittently resistive connection. A start pulse launches one fault procedure. The procedure waits a lead-in delay. It then plays a burst of fault events, where each event applies a drawn resistance level for a drawn on-time. The events are separated by fault-free gaps. A fault-free hold time closes the procedure.

Every duration, the resistance level and the number of events in the burst are drawn from a seeded 32-bit pseudo-random source. Each draw falls between a programmable low and high limit. Reloading the same seed with the same limits replays the same burst cycle for cycle. This lets a rare fault be reproduced at will on the bench. An optional repeat input chains procedures back to back, and the random stream continues between them.

Top module: `irf_burst_gen`

## Requirements
- R1: While reset is low and after it is released, `busy_o` and `fault_o` are 0 and `res_code_o` equals the parameter `REST_CODE`.
- R2: A high `start_i` is acted on only in the idle state. It loads the random register with `seed_i`, or with 1 when `seed_i` is zero, and enters the lead-in phase at that edge. A `start_i` that is high while the block is busy, or during the completion cycle, has no effect.
- R3: Each draw first advances the random register r to (r >> 1) XOR (r[0] ? 32'h80200003 : 0). It then yields lo + (r mod (hi − lo + 1)), using the new r and that parameter's limits. When hi < lo the draw yields lo.
- R4: The draws are made in a fixed order. On start, the lead-in delay is drawn. At lead-in end, the burst length is drawn, then the level, then the on-time. At each on-phase end that is not the last, the gap time is drawn. At each gap end, the level is drawn, then the on-time. At the last on-phase end, the hold time is drawn.
- R5: Each phase (lead-in, on, gap, hold) lasts exactly max(d,1) clock cycles, where d is its drawn duration.
- R6: During an on phase, `fault_o` and `busy_o` are 1. `res_code_o` carries that event's drawn level and stays constant for the whole phase.
- R7: During the lead-in, gap and hold phases, `busy_o` is 1, `fault_o` is 0 and `res_code_o` equals `REST_CODE`. A gap occurs only between two on phases, and the last on phase is followed directly by the hold phase.
- R8: A burst contains exactly max(n,1) on phases, where n is the drawn burst length.
- R9: When the hold phase ends with `repeat_i` low, one completion cycle follows with `busy_o` low, and then the idle state. With `repeat_i` high at that edge, a new lead-in starts at once, drawn from the continuing random register without reseeding.
- R10: Two procedures started from the same seed and the same limits give identical output sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch a procedure from idle |
| repeat_i | input | 1 | Chain another procedure when the hold phase ends |
| seed_i | input | 32 | Seed for the random register |
| dly_lo_i | input | TW | Lead-in delay lower limit, in cycles |
| dly_hi_i | input | TW | Lead-in delay upper limit |
| on_lo_i | input | TW | On-time lower limit |
| on_hi_i | input | TW | On-time upper limit |
| off_lo_i | input | TW | Gap-time lower limit |
| off_hi_i | input | TW | Gap-time upper limit |
| hold_lo_i | input | TW | Hold-time lower limit |
| hold_hi_i | input | TW | Hold-time upper limit |
| lvl_lo_i | input | RW | Resistance level lower limit |
| lvl_hi_i | input | RW | Resistance level upper limit |
| cnt_lo_i | input | LW | Burst length lower limit |
| cnt_hi_i | input | LW | Burst length upper limit |
| res_code_o | output | RW | Resistance code to the potentiometer and switch network |
| fault_o | output | 1 | High while a fault event is applied |
| busy_o | output | 1 | High from the lead-in through the hold phase |

## Verification
The bench builds the generator with 8-bit timers and levels, a 5-bit burst count and a rest code of zero. These narrow widths let single-digit durations cover whole bursts in a few dozen cycles. That leaves room for pinned limits, spread limits, zero durations, reversed limits, a zero seed, a start held through a whole run, and a chained repeat. Each run is predicted from the seed by the draw rule and draw order alone, and compared cycle by cycle.

// File: rtl/irf_burst_gen.sv
module irf_burst_gen #(
  parameter int TW = 16,
  parameter int RW = 8,
  parameter int LW = 5,
  parameter logic [RW-1:0] REST_CODE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          repeat_i,
  input  logic [31:0]   seed_i,
  input  logic [TW-1:0] dly_lo_i,
  input  logic [TW-1:0] dly_hi_i,
  input  logic [TW-1:0] on_lo_i,
  input  logic [TW-1:0] on_hi_i,
  input  logic [TW-1:0] off_lo_i,
  input  logic [TW-1:0] off_hi_i,
  input  logic [TW-1:0] hold_lo_i,
  input  logic [TW-1:0] hold_hi_i,
  input  logic [RW-1:0] lvl_lo_i,
  input  logic [RW-1:0] lvl_hi_i,
  input  logic [LW-1:0] cnt_lo_i,
  input  logic [LW-1:0] cnt_hi_i,
  output logic [RW-1:0] res_code_o,
  output logic          fault_o,
  output logic          busy_o
);

  localparam logic [31:0] POLY = 32'h80200003;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_ON, S_OFF, S_HOLD, S_END} st_t;

  function automatic logic [31:0] nxt(input logic [31:0] v);
    return (v >> 1) ^ (v[0] ? POLY : 32'h0);
  endfunction

  function automatic logic [31:0] pick(input logic [31:0] v, input logic [31:0] lo,
                                       input logic [31:0] hi);
    logic [32:0] span;
    if (hi < lo) return lo;
    span = {1'b0, hi} - {1'b0, lo} + 33'd1;
    return lo + 32'({1'b0, v} % span);
  endfunction

  st_t           st;
  logic [31:0]   lfsr;
  logic [TW-1:0] tmr;
  logic [LW-1:0] left;
  logic [RW-1:0] lvl;

  wire [31:0] base = (st == S_IDLE) ? ((seed_i == 32'h0) ? 32'h1 : seed_i) : lfsr;
  wire [31:0] s1 = nxt(base);
  wire [31:0] s2 = nxt(s1);
  wire [31:0] s3 = nxt(s2);

  wire [TW-1:0] lead_d  = TW'(pick(s1, 32'(dly_lo_i),  32'(dly_hi_i)));
  wire [TW-1:0] off_d   = TW'(pick(s1, 32'(off_lo_i),  32'(off_hi_i)));
  wire [TW-1:0] hold_d  = TW'(pick(s1, 32'(hold_lo_i), 32'(hold_hi_i)));
  wire [LW-1:0] cnt_d   = LW'(pick(s1, 32'(cnt_lo_i),  32'(cnt_hi_i)));
  wire [RW-1:0] lvl_a   = RW'(pick(s2, 32'(lvl_lo_i),  32'(lvl_hi_i)));
  wire [TW-1:0] on_a    = TW'(pick(s3, 32'(on_lo_i),   32'(on_hi_i)));
  wire [RW-1:0] lvl_b   = RW'(pick(s1, 32'(lvl_lo_i),  32'(lvl_hi_i)));
  wire [TW-1:0] on_b    = TW'(pick(s2, 32'(on_lo_i),   32'(on_hi_i)));

  wire expire = (tmr < TW'(2));
  wire last   = (left < LW'(2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      lfsr <= 32'h1;
      tmr  <= '0;
      left <= '0;
      lvl  <= REST_CODE;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          lfsr <= s1;
          tmr  <= lead_d;
          st   <= S_LEAD;
        end
        S_LEAD: if (expire) begin
          left <= cnt_d;
          lvl  <= lvl_a;
          tmr  <= on_a;
          lfsr <= s3;
          st   <= S_ON;
        end else tmr <= tmr - 1'b1;
        S_ON: if (expire) begin
          lfsr <= s1;
          if (last) begin
            tmr <= hold_d;
            st  <= S_HOLD;
          end else begin
            left <= left - 1'b1;
            tmr  <= off_d;
            st   <= S_OFF;
          end
        end else tmr <= tmr - 1'b1;
        S_OFF: if (expire) begin
          lvl  <= lvl_b;
          tmr  <= on_b;
          lfsr <= s2;
          st   <= S_ON;
        end else tmr <= tmr - 1'b1;
        S_HOLD: if (expire) begin
          if (repeat_i) begin
            lfsr <= s1;
            tmr  <= lead_d;
            st   <= S_LEAD;
          end else st <= S_END;
        end else tmr <= tmr - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign fault_o    = (st == S_ON);
  assign res_code_o = fault_o ? lvl : REST_CODE;
  assign busy_o     = (st != S_IDLE) && (st != S_END);

endmodule

// File: rtl/irf_burst_gen_chk.sv
module irf_burst_gen_chk #(
  parameter int RW = 8,
  parameter logic [RW-1:0] REST_CODE = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [RW-1:0] lvl_lo_i,
  input logic [RW-1:0] lvl_hi_i,
  input logic [RW-1:0] res_code_o,
  input logic          fault_o,
  input logic          busy_o
);

  p_fault_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> busy_o);

  p_rest_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_o |-> res_code_o == REST_CODE);

  p_level_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> ((lvl_lo_i <= lvl_hi_i) ? (res_code_o >= lvl_lo_i && res_code_o <= lvl_hi_i)
                                        : (res_code_o == lvl_lo_i)));

  p_level_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o && $past(fault_o) |-> $stable(res_code_o));

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  p_no_lead_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !fault_o);

endmodule

bind irf_burst_gen irf_burst_gen_chk #(.RW(RW), .REST_CODE(REST_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .lvl_lo_i(lvl_lo_i), .lvl_hi_i(lvl_hi_i),
  .res_code_o(res_code_o), .fault_o(fault_o), .busy_o(busy_o)
);

// File: tb/irf_burst_gen_bench.sv
module irf_burst_gen_bench;
  localparam int TW = 8;
  localparam int RW = 8;
  localparam int LW = 5;
  localparam logic [RW-1:0] REST = 8'h00;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0, start_i = 0, repeat_i = 0;
  logic [31:0] seed_i = 0;
  logic [TW-1:0] dly_lo, dly_hi, on_lo, on_hi, off_lo, off_hi, hold_lo, hold_hi;
  logic [RW-1:0] lvl_lo, lvl_hi, res_code_o;
  logic [LW-1:0] cnt_lo, cnt_hi;
  logic fault_o, busy_o;

  int tests = 0, fails = 0, fault_seen = 0, code_sum = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irf_burst_gen #(.TW(TW), .RW(RW), .LW(LW), .REST_CODE(REST)) u_irf_burst_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .repeat_i(repeat_i), .seed_i(seed_i),
    .dly_lo_i(dly_lo), .dly_hi_i(dly_hi), .on_lo_i(on_lo), .on_hi_i(on_hi),
    .off_lo_i(off_lo), .off_hi_i(off_hi), .hold_lo_i(hold_lo), .hold_hi_i(hold_hi),
    .lvl_lo_i(lvl_lo), .lvl_hi_i(lvl_hi), .cnt_lo_i(cnt_lo), .cnt_hi_i(cnt_hi),
    .res_code_o(res_code_o), .fault_o(fault_o), .busy_o(busy_o));

  function automatic logic [31:0] step(input logic [31:0] v);
    return (v >> 1) ^ (v[0] ? 32'h80200003 : 32'h0);
  endfunction

  function automatic int draw(input logic [31:0] v, input int lo, input int hi);
    if (hi < lo) return lo;
    return lo + int'(64'(v) % 64'(hi - lo + 1));
  endfunction

  function automatic int atleast1(input int d);
    return (d < 1) ? 1 : d;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic expect_span(input int n, input bit b, input bit f, input int code, input string req);
    for (int i = 0; i < n; i++) begin
      check(req, "busy", int'(busy_o), int'(b));
      check(req, "fault", int'(fault_o), int'(f));
      check(req, "code", int'(res_code_o), code);
      if (fault_o) fault_seen++;
      code_sum += int'(res_code_o);
      @(negedge clk);
    end
  endtask

  task automatic set_cfg(input int a, input int b, input int c, input int d, input int e, input int f,
                         input int g, input int h, input int i, input int j, input int k, input int l);
    dly_lo = TW'(a); dly_hi = TW'(b); on_lo = TW'(c); on_hi = TW'(d);
    off_lo = TW'(e); off_hi = TW'(f); hold_lo = TW'(g); hold_hi = TW'(h);
    lvl_lo = RW'(i); lvl_hi = RW'(j); cnt_lo = LW'(k); cnt_hi = LW'(l);
  endtask

  // R4 R5 R6 R7 R8 R9: predicted trace from the draw rule and order
  task automatic run_burst(input logic [31:0] seed, input int runs, input bit hold, input string req);
    logic [31:0] r;
    int sd, n, lv, on, off, sf;
    fault_seen = 0; code_sum = 0;
    seed_i = seed;
    repeat_i = (runs > 1);
    @(negedge clk); start_i = 1;
    @(negedge clk); if (!hold) start_i = 0;
    r = (seed == 0) ? 32'h1 : seed;
    for (int run = 0; run < runs; run++) begin
      if (run == runs - 1) repeat_i = 0;
      r = step(r); sd = atleast1(draw(r, int'(dly_lo), int'(dly_hi)));
      expect_span(sd, 1, 0, int'(REST), req);
      r = step(r); n  = atleast1(draw(r, int'(cnt_lo), int'(cnt_hi)));
      r = step(r); lv = draw(r, int'(lvl_lo), int'(lvl_hi));
      r = step(r); on = atleast1(draw(r, int'(on_lo), int'(on_hi)));
      for (int e = 0; e < n; e++) begin
        if (e > 0) begin
          r = step(r); off = atleast1(draw(r, int'(off_lo), int'(off_hi)));
          expect_span(off, 1, 0, int'(REST), req);
          r = step(r); lv = draw(r, int'(lvl_lo), int'(lvl_hi));
          r = step(r); on = atleast1(draw(r, int'(on_lo), int'(on_hi)));
        end
        expect_span(on, 1, 1, lv, req);
      end
      r = step(r); sf = atleast1(draw(r, int'(hold_lo), int'(hold_hi)));
      if (hold) start_i = 0;
      expect_span(sf, 1, 0, int'(REST), req);
    end
    expect_span(2, 0, 0, int'(REST), req);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", "busy in reset", int'(busy_o), 0);
    check("R1", "fault in reset", int'(fault_o), 0);
    check("R1", "code in reset", int'(res_code_o), int'(REST));
    rst_n = 1;
    @(negedge clk);
    check("R1", "busy after reset", int'(busy_o), 0);
  endtask

  task automatic t_fixed;
    set_cfg(3, 3, 4, 4, 2, 2, 5, 5, 8'h5A, 8'h5A, 2, 2);
    run_burst(32'hC0FFEE01, 1, 0, "R5_R8");
  endtask

  task automatic t_spread;
    set_cfg(2, 9, 1, 6, 1, 3, 2, 7, 8'h10, 8'h40, 1, 5);
    run_burst(32'h1234ABCD, 1, 0, "R3_R4");
    run_burst(32'h0BADF00D, 1, 0, "R3_R4");
  endtask

  task automatic t_replay;
    int f1, c1;
    set_cfg(1, 6, 1, 5, 1, 4, 1, 3, 8'h20, 8'hE0, 3, 7);
    run_burst(32'h5EED5EED, 1, 0, "R10");
    f1 = fault_seen; c1 = code_sum;
    run_burst(32'h5EED5EED, 1, 0, "R10");
    check("R10", "replayed fault cycles", fault_seen, f1);
    check("R10", "replayed code sum", code_sum, c1);
  endtask

  task automatic t_zero_seed;
    set_cfg(1, 4, 1, 4, 1, 2, 1, 4, 8'h01, 8'hFF, 1, 4);
    run_burst(32'h0, 1, 0, "R2");
  endtask

  task automatic t_zero_dur;
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 8'h33, 8'h33, 0, 0);
    run_burst(32'h77, 1, 0, "R5_R8");
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 8'h44, 8'h44, 3, 3);
    run_burst(32'h78, 1, 0, "R5_R7");
  endtask

  task automatic t_reversed;
    set_cfg(5, 2, 3, 1, 2, 1, 4, 2, 8'h70, 8'h20, 3, 1);
    run_burst(32'hFACE, 1, 0, "R3");
  endtask

  task automatic t_held_start;
    set_cfg(2, 5, 1, 3, 1, 2, 2, 4, 8'h11, 8'h99, 2, 4);
    run_burst(32'hABCDEF01, 1, 1, "R2");
  endtask

  task automatic t_repeat;
    set_cfg(1, 4, 1, 3, 1, 2, 1, 3, 8'h08, 8'h80, 1, 3);
    run_burst(32'h600DCAFE, 3, 0, "R9");
  endtask

  initial begin
    set_cfg(1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1);
    t_reset;
    t_fixed;
    t_spread;
    t_replay;
    t_zero_seed;
    t_zero_dur;
    t_reversed;
    t_held_start;
    t_repeat;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule